// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer with Clock-Out

This block is a 16-bit timer/counter made of two cascaded byte halves, paired with a 16-bit reload/capture register. Software sets it up through a small register bus: one control register, one mode register, and byte access to the counter and to the reload register. The counter advances on a peripheral clock tick or on falling edges of an external count pin. A second external pin acts as a capture/reload trigger or as a count-direction input. Two sticky flags, a combined interrupt request and a square-wave clock output come out of the block.

The operating mode is decoded each cycle from the configuration bits into one of five named states. The states in priority order are MODE_BAUD, MODE_CLKOUT, MODE_UPDOWN, MODE_CAPTURE and MODE_RELOAD. There are no transitions between states. The mode simply follows the configuration bits on the next cycle after a write. MODE_BAUD is entered when either serial-clock select bit is set. MODE_CLKOUT is entered when the clock-out enable is set. MODE_UPDOWN is entered when the up/down enable is set. MODE_CAPTURE is entered when the capture select is set. Otherwise the block is in MODE_RELOAD.

A two-state phase machine halves the tick rate in MODE_CLKOUT. On each qualifying tick, PH_WAIT goes to PH_STEP and PH_STEP goes back to PH_WAIT. Leaving MODE_CLKOUT forces PH_WAIT.

Top module: `updown_reload_timer`

## Requirements
- R1: After reset, every register reads 00h, and `irq`, `wrap_flag`, `ext_flag` and `clk_out` are 0.
- R2: In MODE_RELOAD with `run` high, each step adds one to the counter. A step at FFFFh loads the reload value and sets the wrap flag (control bit 0).
- R3: With control bit 5 set, a step is a falling edge of `cnt_pin`. The pin passes two synchronising flops, and the edge is a registered 1 followed by a registered 0. With control bit 5 clear, a step is a high `tick`.
- R4: With mode bit 0 set (MODE_UPDOWN), a high `trig_pin` counts up and a low one counts down. Counting up at FFFFh reloads and sets the wrap flag. Counting down when the count equals the reload value loads FFFFh and sets the wrap flag.
- R5: In MODE_UPDOWN, the external flag (control bit 1) toggles on each wrap in either direction. A `trig_pin` edge has no effect, and the external flag does not raise `irq`.
- R6: In MODE_CAPTURE (control bit 6), a synchronised falling edge on `trig_pin` with control bit 4 set copies the counter into the reload register and sets the external flag. In this mode a step at FFFFh wraps the counter to 0000h and sets the wrap flag.
- R7: In MODE_RELOAD, a synchronised falling edge on `trig_pin` with control bit 4 set loads the reload value into the counter and sets the external flag. This load takes precedence over a step in the same cycle.
- R8: In MODE_CLKOUT (mode bit 1), the counter steps on every second tick and reloads at FFFFh. Each reload toggles `clk_out`, and the wrap flag is left unchanged.
- R9: When control bit 2 or bit 3 is set, the capture select is ignored. The counter reloads at FFFFh and the wrap flag is not set.
- R10: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A hardware set or toggle in the same cycle takes precedence over the clear.
- R11: A bus write to a counter byte takes precedence over a hardware reload of that byte in the same cycle.
- R12: `irq` equals the wrap flag OR'd with the external flag. The external flag is excluded in MODE_UPDOWN.
- R13: The register addresses are: 0 control, 1 mode, 2 and 3 counter low and high, 4 and 5 reload low and high. Addresses 6 and 7 read 0. Control bit 7 and mode bits 7:2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Peripheral clock tick |
| run | input | 1 | Count enable |
| cnt_pin | input | 1 | External count pin |
| trig_pin | input | 1 | External trigger/direction pin |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | HALF_W | Write data |
| bus_rdata | output | HALF_W | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| wrap_flag | output | 1 | Wrap flag |
| ext_flag | output | 1 | External flag |
| clk_out | output | 1 | Square-wave output |

## Verification
A wrong mode decode or a wrong counter value shows up on `bus_rdata` the cycle after the step that caused it, because the bench rotates the read address through the registers on every idle cycle. A corrupted flag shows up on `wrap_flag`, `ext_flag` and `irq` on the very next cycle. A missed or extra phase in the clock-out machine shifts the next `clk_out` edge by one tick, and the per-cycle comparison against the reference model reports it there.

// File: rtl/urt_pkg.sv
package urt_pkg;
    typedef enum logic [2:0] {
        MODE_RELOAD,
        MODE_CAPTURE,
        MODE_UPDOWN,
        MODE_CLKOUT,
        MODE_BAUD
    } urt_mode_e;

    typedef enum logic {
        PH_WAIT,
        PH_STEP
    } urt_phase_e;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE   = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd5;

    // control bit positions
    localparam int unsigned B_WRAP    = 0;
    localparam int unsigned B_EXT     = 1;
    localparam int unsigned B_BAUD_RX = 2;
    localparam int unsigned B_BAUD_TX = 3;
    localparam int unsigned B_EXT_EN  = 4;
    localparam int unsigned B_CNT_SRC = 5;
    localparam int unsigned B_CAP_SEL = 6;

    // mode bit positions
    localparam int unsigned B_UPDOWN  = 0;
    localparam int unsigned B_CLKOUT  = 1;

    typedef struct packed {
        logic cap_sel;
        logic cnt_src;
        logic ext_en;
        logic baud_tx;
        logic baud_rx;
        logic clkout_en;
        logic updown_en;
    } urt_cfg_t;
endpackage

// File: rtl/urt_edge_sync.sv
module urt_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign fall  = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/urt_regfile.sv
module urt_regfile
    import urt_pkg::*;
#(
    parameter int unsigned HALF_W = 8,
    localparam int unsigned CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    input  logic              set_wrap,
    input  logic              set_ext,
    input  logic              tog_ext,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  rld,
    output urt_cfg_t          cfg,
    output logic              wrap_q,
    output logic              ext_q,
    output logic [HALF_W-1:0] rdata
);
    urt_cfg_t cfg_q;
    logic     wrap_d, ext_d;
    logic     ctrl_wr, mode_wr;
    logic     unused_bits;

    assign ctrl_wr     = wr_en && (addr == A_CTRL);
    assign mode_wr     = wr_en && (addr == A_MODE);
    assign unused_bits = ^wdata;

    always_comb begin
        wrap_d = wrap_q;
        if (ctrl_wr && !wdata[B_WRAP]) wrap_d = 1'b0;
        if (set_wrap) wrap_d = 1'b1;
        ext_d = ext_q;
        if (ctrl_wr && !wdata[B_EXT]) ext_d = 1'b0;
        if (set_ext) ext_d = 1'b1;
        if (tog_ext) ext_d = ~ext_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            wrap_q <= 1'b0;
            ext_q  <= 1'b0;
        end else begin
            wrap_q <= wrap_d;
            ext_q  <= ext_d;
            if (ctrl_wr) begin
                cfg_q.baud_rx <= wdata[B_BAUD_RX];
                cfg_q.baud_tx <= wdata[B_BAUD_TX];
                cfg_q.ext_en  <= wdata[B_EXT_EN];
                cfg_q.cnt_src <= wdata[B_CNT_SRC];
                cfg_q.cap_sel <= wdata[B_CAP_SEL];
            end
            if (mode_wr) begin
                cfg_q.updown_en <= wdata[B_UPDOWN];
                cfg_q.clkout_en <= wdata[B_CLKOUT];
            end
        end
    end

    assign cfg = cfg_q;

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: begin
                rdata[B_WRAP]    = wrap_q;
                rdata[B_EXT]     = ext_q;
                rdata[B_BAUD_RX] = cfg_q.baud_rx;
                rdata[B_BAUD_TX] = cfg_q.baud_tx;
                rdata[B_EXT_EN]  = cfg_q.ext_en;
                rdata[B_CNT_SRC] = cfg_q.cnt_src;
                rdata[B_CAP_SEL] = cfg_q.cap_sel;
            end
            A_MODE: begin
                rdata[B_UPDOWN] = cfg_q.updown_en;
                rdata[B_CLKOUT] = cfg_q.clkout_en;
            end
            A_CNT_LO: rdata = cnt[HALF_W-1:0];
            A_CNT_HI: rdata = cnt[CNT_W-1:HALF_W];
            A_RLD_LO: rdata = rld[HALF_W-1:0];
            A_RLD_HI: rdata = rld[CNT_W-1:HALF_W];
            default:  rdata = '0;
        endcase
    end

    // a set wrap flag survives every cycle without a clearing write
    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (wrap_q && !(ctrl_wr && !wdata[B_WRAP])) |=> wrap_q);
endmodule

// File: rtl/urt_core.sv
module urt_core
    import urt_pkg::*;
#(
    parameter int unsigned HALF_W = 8,
    localparam int unsigned CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  urt_cfg_t          cfg,
    input  logic              run,
    input  logic              tick,
    input  logic              cnt_fall,
    input  logic              trig_fall,
    input  logic              trig_level,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  rld_q,
    output logic              set_wrap,
    output logic              set_ext,
    output logic              tog_ext,
    output logic              clk_q,
    output urt_mode_e         mode
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    urt_phase_e       phase_q, phase_d;
    logic             step;
    logic [CNT_W-1:0] hw_cnt, hw_rld, cnt_d, rld_d;
    logic             tog_pin;
    logic             cnt_wr, rld_wr, trig_hit;

    assign cnt_wr   = wr_en && (addr == A_CNT_LO || addr == A_CNT_HI);
    assign rld_wr   = wr_en && (addr == A_RLD_LO || addr == A_RLD_HI);
    assign trig_hit = cfg.ext_en && trig_fall;

    // mode decode, fixed priority
    always_comb begin
        if (cfg.baud_rx || cfg.baud_tx) mode = MODE_BAUD;
        else if (cfg.clkout_en)         mode = MODE_CLKOUT;
        else if (cfg.updown_en)         mode = MODE_UPDOWN;
        else if (cfg.cap_sel)           mode = MODE_CAPTURE;
        else                            mode = MODE_RELOAD;
    end

    // half-rate phase machine for clock-out
    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_WAIT;
        else     phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_WAIT: if (mode == MODE_CLKOUT && run && tick) phase_d = PH_STEP;
            PH_STEP: if (mode != MODE_CLKOUT || (run && tick)) phase_d = PH_WAIT;
        endcase
    end

    always_comb begin
        unique case (mode)
            MODE_CLKOUT: step = run && tick && (phase_q == PH_STEP);
            default:     step = run && (cfg.cnt_src ? cnt_fall : tick);
        endcase
    end

    // hardware next state
    always_comb begin
        hw_cnt   = cnt_q;
        hw_rld   = rld_q;
        set_wrap = 1'b0;
        set_ext  = 1'b0;
        tog_ext  = 1'b0;
        tog_pin  = 1'b0;
        unique case (mode)
            MODE_BAUD: begin
                if (step) hw_cnt = (cnt_q == ALL_ONES) ? rld_q : cnt_q + 1'b1;
                if (trig_hit) set_ext = 1'b1;
            end
            MODE_CLKOUT: begin
                if (step) begin
                    if (cnt_q == ALL_ONES) begin
                        hw_cnt  = rld_q;
                        tog_pin = 1'b1;
                    end else begin
                        hw_cnt = cnt_q + 1'b1;
                    end
                end
                if (trig_hit) set_ext = 1'b1;
            end
            MODE_UPDOWN: begin
                if (step) begin
                    if (trig_level) begin
                        if (cnt_q == ALL_ONES) begin
                            hw_cnt   = rld_q;
                            set_wrap = 1'b1;
                            tog_ext  = 1'b1;
                        end else begin
                            hw_cnt = cnt_q + 1'b1;
                        end
                    end else begin
                        if (cnt_q == rld_q) begin
                            hw_cnt   = ALL_ONES;
                            set_wrap = 1'b1;
                            tog_ext  = 1'b1;
                        end else begin
                            hw_cnt = cnt_q - 1'b1;
                        end
                    end
                end
            end
            MODE_CAPTURE: begin
                if (step) begin
                    hw_cnt = cnt_q + 1'b1;
                    if (cnt_q == ALL_ONES) set_wrap = 1'b1;
                end
                if (trig_hit) begin
                    hw_rld  = cnt_q;
                    set_ext = 1'b1;
                end
            end
            MODE_RELOAD: begin
                if (step) begin
                    if (cnt_q == ALL_ONES) begin
                        hw_cnt   = rld_q;
                        set_wrap = 1'b1;
                    end else begin
                        hw_cnt = cnt_q + 1'b1;
                    end
                end
                if (trig_hit) begin
                    hw_cnt  = rld_q;
                    set_ext = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // bus writes take precedence byte by byte
    always_comb begin
        cnt_d = hw_cnt;
        rld_d = hw_rld;
        if (wr_en && addr == A_CNT_LO) cnt_d[HALF_W-1:0]     = wdata;
        if (wr_en && addr == A_CNT_HI) cnt_d[CNT_W-1:HALF_W] = wdata;
        if (wr_en && addr == A_RLD_LO) rld_d[HALF_W-1:0]     = wdata;
        if (wr_en && addr == A_RLD_HI) rld_d[CNT_W-1:HALF_W] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rld_q <= '0;
            clk_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            rld_q <= rld_d;
            if (tog_pin) clk_q <= ~clk_q;
        end
    end

    assert_up_reload_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RELOAD && step && cnt_q == ALL_ONES && !trig_hit && !cnt_wr)
        |=> cnt_q == $past(rld_q));

    assert_down_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_UPDOWN && step && !trig_level && cnt_q == rld_q && !cnt_wr)
        |=> cnt_q == ALL_ONES);

    assert_capture_copy_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CAPTURE && trig_hit && !rld_wr) |=> rld_q == $past(cnt_q));

    assert_pin_toggle_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(clk_q) |-> $past(mode == MODE_CLKOUT && step && cnt_q == ALL_ONES));
endmodule

// File: rtl/updown_reload_timer.sv
module updown_reload_timer
    import urt_pkg::*;
#(
    parameter int unsigned HALF_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              run,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wrap_flag,
    output logic              ext_flag,
    output logic              clk_out
);
    localparam int unsigned CNT_W = 2 * HALF_W;

    urt_cfg_t         cfg;
    urt_mode_e        mode;
    logic             cnt_fall, cnt_level, trig_fall, trig_level;
    logic [CNT_W-1:0] cnt, rld;
    logic             set_wrap, set_ext, tog_ext;
    logic             unused_level;

    assign unused_level = cnt_level;

    urt_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst(rst), .pin(cnt_pin), .level(cnt_level), .fall(cnt_fall)
    );

    urt_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk(clk), .rst(rst), .pin(trig_pin), .level(trig_level), .fall(trig_fall)
    );

    urt_core #(.HALF_W(HALF_W)) u_core (
        .clk(clk), .rst(rst), .cfg(cfg), .run(run), .tick(tick),
        .cnt_fall(cnt_fall), .trig_fall(trig_fall), .trig_level(trig_level),
        .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .cnt_q(cnt), .rld_q(rld), .set_wrap(set_wrap), .set_ext(set_ext),
        .tog_ext(tog_ext), .clk_q(clk_out), .mode(mode)
    );

    urt_regfile #(.HALF_W(HALF_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .set_wrap(set_wrap), .set_ext(set_ext), .tog_ext(tog_ext),
        .cnt(cnt), .rld(rld), .cfg(cfg), .wrap_q(wrap_flag), .ext_q(ext_flag),
        .rdata(bus_rdata)
    );

    assign irq = wrap_flag || (ext_flag && mode != MODE_UPDOWN);

    // serial-clock modes never raise the wrap flag
    assert_baud_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BAUD && !wrap_flag) |=> !wrap_flag);
endmodule

// File: tb/sim_updown_reload_timer.sv
`timescale 1ns/1ps
module sim_updown_reload_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, run = 1'b0, cnt_pin = 1'b0, trig_pin = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq, wrap_flag, ext_flag, clk_out;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    updown_reload_timer u0 (
        .clk(clk), .rst(rst), .tick(tick), .run(run), .cnt_pin(cnt_pin),
        .trig_pin(trig_pin), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .wrap_flag(wrap_flag), .ext_flag(ext_flag), .clk_out(clk_out)
    );

    // ---------------- behavioural reference model ----------------
    int m_cnt, m_rld, m_cfg, m_mode, m_wrap, m_ext, m_clk, m_ph;
    int cs1, cs2, cs3, ts1, ts2, ts3;

    function automatic int bitof(int v, int b);
        return (v >> b) & 1;
    endfunction

    function automatic int m_sel();
        if (bitof(m_cfg, 2) || bitof(m_cfg, 3)) return 4;
        if (bitof(m_mode, 1)) return 3;
        if (bitof(m_mode, 0)) return 2;
        if (bitof(m_cfg, 6)) return 1;
        return 0;
    endfunction

    function automatic int m_read(int a);
        case (a)
            0: return (m_cfg & 8'h7C) | (m_ext << 1) | m_wrap;
            1: return m_mode & 3;
            2: return m_cnt & 255;
            3: return (m_cnt >> 8) & 255;
            4: return m_rld & 255;
            5: return (m_rld >> 8) & 255;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int a);
        case (a)
            0: return "R10";
            1: return "R13";
            2, 3: return "R2";
            4, 5: return "R6";
            default: return "R13";
        endcase
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int md, stp, cf, tf, hit, nc, nr, sw, se, te, tp, a, d, wr;
        if (rst) begin
            m_cnt = 0; m_rld = 0; m_cfg = 0; m_mode = 0; m_wrap = 0; m_ext = 0;
            m_clk = 0; m_ph = 0; cs1 = 0; cs2 = 0; cs3 = 0; ts1 = 0; ts2 = 0; ts3 = 0;
        end else begin
            a = int'(bus_addr); d = int'(bus_wdata); wr = int'(bus_wr);
            cf = (cs3 == 1 && cs2 == 0) ? 1 : 0;
            tf = (ts3 == 1 && ts2 == 0) ? 1 : 0;
            md = m_sel();
            if (md == 3) stp = (run && tick && m_ph == 1) ? 1 : 0;
            else stp = run ? (bitof(m_cfg, 5) ? cf : int'(tick)) : 0;
            hit = bitof(m_cfg, 4) & tf;
            nc = m_cnt; nr = m_rld; sw = 0; se = 0; te = 0; tp = 0;
            case (md)
                4: begin
                    if (stp) nc = (m_cnt == 65535) ? m_rld : m_cnt + 1;
                    if (hit) se = 1;
                end
                3: begin
                    if (stp) begin
                        if (m_cnt == 65535) begin nc = m_rld; tp = 1; end
                        else nc = m_cnt + 1;
                    end
                    if (hit) se = 1;
                end
                2: if (stp) begin
                    if (ts2 == 1) begin
                        if (m_cnt == 65535) begin nc = m_rld; sw = 1; te = 1; end
                        else nc = m_cnt + 1;
                    end else begin
                        if (m_cnt == m_rld) begin nc = 65535; sw = 1; te = 1; end
                        else nc = m_cnt - 1;
                    end
                end
                1: begin
                    if (stp) begin
                        nc = (m_cnt + 1) % 65536;
                        if (m_cnt == 65535) sw = 1;
                    end
                    if (hit) begin nr = m_cnt; se = 1; end
                end
                default: begin
                    if (stp) begin
                        if (m_cnt == 65535) begin nc = m_rld; sw = 1; end
                        else nc = m_cnt + 1;
                    end
                    if (hit) begin nc = m_rld; se = 1; end
                end
            endcase
            if (wr && a == 2) nc = (nc & 16'hFF00) | d;
            if (wr && a == 3) nc = (nc & 16'h00FF) | (d << 8);
            if (wr && a == 4) nr = (nr & 16'hFF00) | d;
            if (wr && a == 5) nr = (nr & 16'h00FF) | (d << 8);
            if (wr && a == 0 && !bitof(d, 0)) m_wrap = 0;
            if (sw) m_wrap = 1;
            if (te) m_ext = 1 - m_ext;
            else begin
                if (wr && a == 0 && !bitof(d, 1)) m_ext = 0;
                if (se) m_ext = 1;
            end
            if (tp) m_clk = 1 - m_clk;
            if (md != 3) m_ph = 0;
            else if (run && tick) m_ph = 1 - m_ph;
            if (wr && a == 0) m_cfg = d & 8'h7C;
            if (wr && a == 1) m_mode = d & 3;
            m_cnt = nc; m_rld = nr;
            cs3 = cs2; cs2 = cs1; cs1 = int'(cnt_pin);
            ts3 = ts2; ts2 = ts1; ts1 = int'(trig_pin);
        end
        #1;
        if (!rst) begin
            chk(tag_of(int'(bus_addr)), "rdata", int'(bus_rdata), m_read(int'(bus_addr)));
            chk("R12", "irq", int'(irq), (m_wrap || (m_ext && m_sel() != 2)) ? 1 : 0);
            chk("R10", "wrap_flag", int'(wrap_flag), m_wrap);
            chk("R5", "ext_flag", int'(ext_flag), m_ext);
            chk("R8", "clk_out", int'(clk_out), m_clk);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_wr = 1'b0;
            bus_addr = bus_addr + 3'd1;
        end
    endtask

    task automatic wreg(int a, int d);
        @(negedge clk);
        bus_addr = 3'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(int a, int exp, string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 3'(a);
        @(posedge clk); #1.5;
        chk(tag, "directed read", int'(bus_rdata), exp);
    endtask

    task automatic pin_trig_fall();
        @(negedge clk); trig_pin = 1'b1; idle(3);
        @(negedge clk); trig_pin = 1'b0; idle(4);
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        // R1 reset state
        for (int a = 0; a < 6; a++) rd_expect(a, 0, "R1");
        chk("R1", "irq after reset", int'(irq), 0);
        chk("R1", "clk_out after reset", int'(clk_out), 0);

        // R13 reserved bits and unused addresses
        wreg(1, 8'hFF); rd_expect(1, 8'h03, "R13");
        wreg(1, 0); rd_expect(6, 0, "R13"); rd_expect(7, 0, "R13");

        // R2 reload at FFFFh
        run = 1'b1;
        wreg(4, 8'h34); wreg(5, 8'h12); wreg(2, 8'hFD); wreg(3, 8'hFF);
        @(negedge clk); tick = 1'b1; idle(2);
        @(negedge clk); tick = 1'b0;
        rd_expect(2, 8'h34, "R2"); rd_expect(3, 8'h12, "R2");
        rd_expect(0, 8'h01, "R2");

        // R10 write 1 keeps, write 0 clears
        wreg(0, 8'h01); rd_expect(0, 8'h01, "R10");
        wreg(0, 8'h00); rd_expect(0, 8'h00, "R10");

        // R11 bus write wins over reload
        wreg(2, 8'hFF); wreg(3, 8'hFF);
        @(negedge clk); tick = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h55; bus_wr = 1'b1;
        @(negedge clk); tick = 1'b0; bus_wr = 1'b0;
        rd_expect(2, 8'h55, "R11"); rd_expect(3, 8'h12, "R11");
        wreg(0, 8'h00);

        // R3 count pin edges, tick ignored
        wreg(0, 8'h20); wreg(2, 0); wreg(3, 0);
        tick = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); cnt_pin = 1'b1; idle(3);
            @(negedge clk); cnt_pin = 1'b0; idle(3);
        end
        idle(4); tick = 1'b0;
        rd_expect(2, 3, "R3");

        // R7 trigger reload
        run = 1'b0;
        wreg(0, 8'h10); wreg(2, 8'h00); wreg(3, 8'h01);
        pin_trig_fall();
        rd_expect(2, 8'h34, "R7"); rd_expect(0, 8'h12, "R7");
        chk("R7", "irq on external flag", int'(irq), 1);

        // R6 capture and wrap to zero
        wreg(0, 8'h50); wreg(2, 8'h67); wreg(3, 8'h45);
        pin_trig_fall();
        rd_expect(4, 8'h67, "R6"); rd_expect(5, 8'h45, "R6");
        wreg(2, 8'hFF); wreg(3, 8'hFF);
        run = 1'b1; @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
        rd_expect(3, 0, "R6"); rd_expect(0, 8'h53, "R6");
        wreg(0, 8'h00);

        // R4/R5 up/down
        wreg(4, 8'h10); wreg(5, 0); wreg(2, 8'h12); wreg(3, 0);
        wreg(0, 8'h10); wreg(1, 8'h01);
        @(negedge clk); tick = 1'b1; idle(2);
        @(negedge clk); tick = 1'b0;
        rd_expect(2, 8'hFF, "R4"); rd_expect(3, 8'hFF, "R4");
        rd_expect(0, 8'h13, "R5");
        wreg(0, 8'h12);
        chk("R5", "irq masked in up/down", int'(irq), 0);
        pin_trig_fall();
        rd_expect(0, 8'h12, "R5");
        @(negedge clk); trig_pin = 1'b1; idle(3);
        @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
        rd_expect(2, 8'h10, "R4"); rd_expect(0, 8'h11, "R5");
        wreg(0, 8'h00); wreg(1, 0);

        // R8 clock-out
        wreg(4, 8'hFE); wreg(5, 8'hFF); wreg(2, 8'hFE); wreg(3, 8'hFF);
        wreg(1, 8'h02);
        @(negedge clk); tick = 1'b1; idle(11);
        @(negedge clk); tick = 1'b0;
        chk("R8", "clk_out toggles", int'(clk_out), 1);
        rd_expect(0, 8'h00, "R8");
        wreg(1, 0);

        // R9 serial-clock forcing
        wreg(0, 8'h44); wreg(4, 0); wreg(5, 8'h20); wreg(2, 8'hFF); wreg(3, 8'hFF);
        @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
        rd_expect(3, 8'h20, "R9"); rd_expect(0, 8'h44, "R9");
        wreg(0, 0);

        // mixed stimulus against the model
        for (int blk = 0; blk < 12; blk++) begin
            wreg(0, $urandom & 8'h7F);
            wreg(1, $urandom & 3);
            wreg(2, 8'hF0 | ($urandom & 15)); wreg(3, 8'hFF);
            for (int c = 0; c < 60; c++) begin
                @(negedge clk);
                bus_wr = 1'b0; bus_addr = bus_addr + 3'd1;
                tick = 1'($urandom); cnt_pin = 1'($urandom);
                trig_pin = 1'($urandom); run = (($urandom & 7) != 0);
            end
        end

        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule